// File: doc/BRIEF.md
# Soft-Reset and Channel Alignment Sequencer

This block turns a single run/reset control bit into a timed soft-reset sequence for a two-channel audio sample path. A write of 0 to the control bit does three things. It raises both per-channel zero flags on the next clock. It opens an alignment window. It asserts an internal reset a fixed number of sample strobes later. A write of 1 releases the internal reset after a shorter number of sample strobes. The flags then drop two sample strobes after that release. While the internal reset is held, the downstream digital processing stays powered down and its output sits at the idle mid-rail level.

While both flags are high, an alignment request clears a free-running sample-phase counter elsewhere in the chip. The same request forces the sample data to zero for a short window so that the jump in phase is blanked. Every delay is counted in sample-rate strobes on the system clock. Because a write can land anywhere inside a sample period, each delay spans a range of one period of real time. A control-bit reversal that arrives before its pending delay finishes cancels that transition.

Top module: `softrst_sync_seq`

## Requirements
- R1: After synchronous reset, int_rst, zflag_l, zflag_r, force_zero and cnt_clr are all 0.
- R2: On the first clock edge that samples run_ctl at 0 after it was 1, both zflag_l and zflag_r are 1 after that edge.
- R3: int_rst goes to 1 on the edge of the third fs_tick strobe after the edge that first saw run_ctl at 0. A strobe on that same edge is not counted.
- R4: int_rst goes to 0 on the edge of the second fs_tick strobe after the edge that first saw run_ctl at 1.
- R5: Both flags go to 0 on the edge of the second fs_tick strobe after the edge on which int_rst went to 0.
- R6: An align_req pulse seen while both flags are 1 makes cnt_clr 1 for exactly the following cycle. It also sets force_zero from that same edge until the edge of the third fs_tick strobe after it.
- R7: An align_req pulse seen while either flag is 0 leaves cnt_clr and force_zero unchanged at 0.
- R8: An accepted align_req that arrives while force_zero is 1 pulses cnt_clr again and restarts the blanking count. force_zero then ends on the third strobe after the later request.
- R9: An align_req is accepted on the cycle right after the write of 0, before int_rst has asserted.
- R10: If run_ctl returns to 1 before the entry delay ends, int_rst never asserts. The flags then drop on the second fs_tick strobe after the edge that saw the return.
- R11: If run_ctl returns to 0 while the release delay is running, int_rst stays 1 and the flags stay 1. A later write of 1 counts its release delay from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fs_tick | input | 1 | One-cycle sample-rate strobe |
| run_ctl | input | 1 | Control bit: 1 normal operation, 0 soft reset |
| align_req | input | 1 | One-cycle request to realign the sample-phase counter |
| int_rst | output | 1 | Internal reset of the digital path, active high |
| zflag_l | output | 1 | Left-channel zero flag, also the alignment window |
| zflag_r | output | 1 | Right-channel zero flag, also the alignment window |
| force_zero | output | 1 | Forces sample data to zero while high |
| cnt_clr | output | 1 | One-cycle clear for the sample-phase counter |

## Verification
On every cycle the assertions check several local rules. The internal reset changes only on a strobe and in the direction run_ctl asks for. The flags rise right after a write of 0 and fall only on a strobe while the reset is released. A counter clear always traces back to a request seen inside the window, and blanking never starts without a clear. The exact strobe on which each delay ends cannot be seen from one cycle, so the bench's scenarios have to show it. The same goes for cancelling a pending entry or release, restarting the blanking, and accepting a request before the reset asserts. The scenarios predict every output edge from the strobe schedule and match each edge against the design.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

   typedef enum logic [1:0] {
      RP_RUN   = 2'd0,
      RP_ENTER = 2'd1,
      RP_HELD  = 2'd2,
      RP_LEAVE = 2'd3
   } rp_state_t;

   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/ssq_rst_path.sv
module ssq_rst_path
   import ssq_pkg::*;
#(
   parameter int unsigned ENTER_STB = 3,
   parameter int unsigned LEAVE_STB = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fs_tick,
   input  logic run_ctl,
   output logic int_rst,
   output logic fall_evt,
   output logic rel_evt
);
   localparam int unsigned MAX_STB = (ENTER_STB > LEAVE_STB) ? ENTER_STB : LEAVE_STB;
   localparam int unsigned CW      = cnt_w(MAX_STB);
   localparam logic [CW-1:0] ENTER_LAST = CW'(ENTER_STB - 1);
   localparam logic [CW-1:0] LEAVE_LAST = CW'(LEAVE_STB - 1);

   if (ENTER_STB < 1 || LEAVE_STB < 1) begin : g_bad_delay
      $error("ssq_rst_path: delays must be at least one strobe");
   end

   rp_state_t     state;
   logic [CW-1:0] cnt;
   logic          ctrl_q;
   logic          rise_evt;

   assign fall_evt = ctrl_q & ~run_ctl;
   assign rise_evt = ~ctrl_q & run_ctl;
   assign int_rst  = (state == RP_HELD) || (state == RP_LEAVE);
   assign rel_evt  = ((state == RP_ENTER) && rise_evt) ||
                     ((state == RP_LEAVE) && !fall_evt && fs_tick && (cnt == LEAVE_LAST));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= RP_RUN;
         cnt    <= '0;
         ctrl_q <= 1'b1;
      end else begin
         ctrl_q <= run_ctl;
         unique case (state)
            RP_RUN: begin
               if (fall_evt) begin
                  state <= RP_ENTER;
                  cnt   <= '0;
               end
            end
            RP_ENTER: begin
               if (rise_evt) begin
                  state <= RP_RUN;
               end else if (fs_tick) begin
                  if (cnt == ENTER_LAST) begin
                     state <= RP_HELD;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            RP_HELD: begin
               if (rise_evt) begin
                  state <= RP_LEAVE;
                  cnt   <= '0;
               end
            end
            RP_LEAVE: begin
               if (fall_evt) begin
                  state <= RP_HELD;
               end else if (fs_tick) begin
                  if (cnt == LEAVE_LAST) begin
                     state <= RP_RUN;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: state <= RP_RUN;
         endcase
      end
   end

   // R3: entry lands only on a strobe while the bit asks for reset
   a_r3_entry_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_rst) |-> ($past(fs_tick) && !$past(run_ctl)));

   // R4: release lands only on a strobe while the bit asks for run
   a_r4_exit_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_rst) |-> ($past(fs_tick) && $past(run_ctl)));

endmodule

// File: rtl/ssq_flag_win.sv
module ssq_flag_win
   import ssq_pkg::*;
#(
   parameter int unsigned NUM_CH   = 2,
   parameter int unsigned HOLD_STB = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fs_tick,
   input  logic              fall_evt,
   input  logic              rel_evt,
   input  logic              int_rst,
   output logic [NUM_CH-1:0] zflag,
   output logic              win
);
   localparam int unsigned CW = cnt_w(HOLD_STB);
   localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_STB - 1);

   if (NUM_CH < 1 || HOLD_STB < 1) begin : g_bad_cfg
      $error("ssq_flag_win: need at least one channel and one hold strobe");
   end

   logic          hold_act;
   logic [CW-1:0] hcnt;
   logic          hold_done;

   assign hold_done = hold_act && !fall_evt && !rel_evt && fs_tick && (hcnt == HOLD_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_act <= 1'b0;
         hcnt     <= '0;
      end else if (fall_evt) begin
         hold_act <= 1'b0;
         hcnt     <= '0;
      end else if (rel_evt) begin
         hold_act <= 1'b1;
         hcnt     <= '0;
      end else if (hold_act && fs_tick) begin
         if (hcnt == HOLD_LAST) begin
            hold_act <= 1'b0;
            hcnt     <= '0;
         end else begin
            hcnt <= hcnt + 1'b1;
         end
      end
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            zflag[ch] <= 1'b0;
         end else if (fall_evt) begin
            zflag[ch] <= 1'b1;
         end else if (hold_done) begin
            zflag[ch] <= 1'b0;
         end
      end
   end

   assign win = &zflag;

   // R2: a write of 0 raises every flag on the next cycle
   a_r2_flags_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      fall_evt |=> (&zflag));

   // R5: flags fall only on a strobe and only with the reset released
   a_r5_flags_drop_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(win) |-> ($past(fs_tick) && !int_rst));

endmodule

// File: rtl/ssq_blank.sv
module ssq_blank
   import ssq_pkg::*;
#(
   parameter int unsigned BLANK_STB       = 3,
   parameter bit          RESTART_ON_SYNC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fs_tick,
   input  logic align_req,
   input  logic win,
   output logic cnt_clr,
   output logic force_zero
);
   localparam int unsigned CW = cnt_w(BLANK_STB);
   localparam logic [CW-1:0] BLANK_LAST = CW'(BLANK_STB - 1);

   if (BLANK_STB < 1) begin : g_bad_blank
      $error("ssq_blank: blanking needs at least one strobe");
   end

   logic          accept;
   logic [CW-1:0] bcnt;

   if (RESTART_ON_SYNC) begin : g_restart
      assign accept = align_req & win;
   end else begin : g_hold
      assign accept = align_req & win & ~force_zero;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_clr    <= 1'b0;
         force_zero <= 1'b0;
         bcnt       <= '0;
      end else begin
         cnt_clr <= accept;
         if (accept) begin
            force_zero <= 1'b1;
            bcnt       <= '0;
         end else if (force_zero && fs_tick) begin
            if (bcnt == BLANK_LAST) begin
               force_zero <= 1'b0;
               bcnt       <= '0;
            end else begin
               bcnt <= bcnt + 1'b1;
            end
         end
      end
   end

   // R6: blanking never starts without a counter clear
   a_r6_blank_with_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(force_zero) |-> cnt_clr);

   // R6: a clear always comes from a request inside the window
   a_r6_clear_from_window: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |-> ($past(align_req) && $past(win)));

   // R7: a request outside the window produces no clear
   a_r7_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (align_req && !win) |=> !cnt_clr);

endmodule

// File: rtl/softrst_sync_seq.sv
module softrst_sync_seq #(
   parameter int unsigned ENTER_STB       = 3,
   parameter int unsigned LEAVE_STB       = 2,
   parameter int unsigned HOLD_STB        = 2,
   parameter int unsigned BLANK_STB       = 3,
   parameter bit          RESTART_ON_SYNC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fs_tick,
   input  logic run_ctl,
   input  logic align_req,
   output logic int_rst,
   output logic zflag_l,
   output logic zflag_r,
   output logic force_zero,
   output logic cnt_clr
);
   localparam int unsigned NUM_CH = 2;

   logic              fall_evt;
   logic              rel_evt;
   logic              win;
   logic [NUM_CH-1:0] zflag;

   ssq_rst_path #(
      .ENTER_STB (ENTER_STB),
      .LEAVE_STB (LEAVE_STB)
   ) u_rst (
      .clk      (clk),
      .rst_n    (rst_n),
      .fs_tick  (fs_tick),
      .run_ctl  (run_ctl),
      .int_rst  (int_rst),
      .fall_evt (fall_evt),
      .rel_evt  (rel_evt)
   );

   ssq_flag_win #(
      .NUM_CH   (NUM_CH),
      .HOLD_STB (HOLD_STB)
   ) u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .fs_tick  (fs_tick),
      .fall_evt (fall_evt),
      .rel_evt  (rel_evt),
      .int_rst  (int_rst),
      .zflag    (zflag),
      .win      (win)
   );

   ssq_blank #(
      .BLANK_STB       (BLANK_STB),
      .RESTART_ON_SYNC (RESTART_ON_SYNC)
   ) u_blank (
      .clk        (clk),
      .rst_n      (rst_n),
      .fs_tick    (fs_tick),
      .align_req  (align_req),
      .win        (win),
      .cnt_clr    (cnt_clr),
      .force_zero (force_zero)
   );

   assign zflag_l = zflag[0];
   assign zflag_r = zflag[1];

endmodule

// File: tb/tb_softrst_sync_seq.sv
module tb_softrst_sync_seq;

   localparam int P = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fs_tick = 1'b0;
   logic run_ctl = 1'b1;
   logic align_req = 1'b0;
   logic int_rst, zflag_l, zflag_r, force_zero, cnt_clr;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   bit mon_on = 1'b0;
   bit done = 1'b0;

   typedef struct {
      int    cyc;
      int    sig;
      bit    val;
      string req;
   } ev_t;

   ev_t q[$];
   logic [4:0] prev = '0;

   softrst_sync_seq dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .fs_tick    (fs_tick),
      .run_ctl    (run_ctl),
      .align_req  (align_req),
      .int_rst    (int_rst),
      .zflag_l    (zflag_l),
      .zflag_r    (zflag_r),
      .force_zero (force_zero),
      .cnt_clr    (cnt_clr)
   );

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   // strobe on every edge whose index is a multiple of P
   always @(negedge clk) fs_tick = ((cyc + 1) % P == 0);

   function automatic int nth(input int c, input int n);
      int k = c;
      int m = 0;
      while (m < n) begin
         k++;
         if (k % P == 0) m++;
      end
      return k;
   endfunction

   task automatic push(input int c, input int s, input bit v, input string req);
      ev_t e;
      e.cyc = c; e.sig = s; e.val = v; e.req = req;
      q.push_back(e);
   endtask

   task automatic push_flags(input int c, input bit v, input string req);
      push(c, 1, v, req);
      push(c, 2, v, req);
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // scoreboard monitor: every output edge must match a predicted item
   always @(negedge clk) begin
      logic [4:0] cur;
      cur = {cnt_clr, force_zero, zflag_r, zflag_l, int_rst};
      if (mon_on) begin
         for (int s = 0; s < 5; s++) begin
            if (cur[s] != prev[s]) begin
               int idx;
               idx = -1;
               for (int i = 0; i < q.size(); i++)
                  if (idx < 0 && q[i].sig == s) idx = i;
               if (idx < 0) begin
                  chk(1'b0, "unexpected", $sformatf("edge on output %0d at cycle %0d", s, cyc),
                      int'(cur[s]), int'(prev[s]));
               end else begin
                  chk(q[idx].val == cur[s], q[idx].req, $sformatf("value of output %0d", s),
                      int'(cur[s]), int'(q[idx].val));
                  chk(q[idx].cyc == cyc, q[idx].req, $sformatf("cycle of output %0d edge", s),
                      cyc, q[idx].cyc);
                  q.delete(idx);
               end
            end
         end
      end
      prev = cur;
   end

   task automatic wr(input bit v, output int e);
      @(negedge clk);
      run_ctl = v;
      e = cyc + 1;
   endtask

   task automatic fire_sync(input bit in_win, input bit fz_rise, input bit fz_fall,
                            input string req, output int es);
      @(negedge clk);
      es = cyc + 1;
      if (in_win) begin
         if (fz_rise) push(es, 3, 1'b1, req);
         push(es, 4, 1'b1, req);
         push(es + 1, 4, 1'b0, req);
         if (fz_fall) push(nth(es, 3), 3, 1'b0, req);
      end
      align_req = 1'b1;
      @(negedge clk);
      align_req = 1'b0;
   endtask

   task automatic settle();
      int guard = 0;
      while (q.size() != 0 && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_run();
      foreach (q[i])
         chk(1'b0, q[i].req, $sformatf("missing edge on output %0d", q[i].sig), -1, q[i].cyc);
      q.delete();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // watchdog
   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         chk(1'b0, "watchdog", "run did not finish", cyc, 150000);
         finish_run();
      end
   end

   initial begin
      int e, e2, e3, r, es, es2;

      repeat (5) @(negedge clk);
      // R1: reset state
      chk(int_rst == 1'b0, "R1", "int_rst in reset", int'(int_rst), 0);
      chk(zflag_l == 1'b0, "R1", "zflag_l in reset", int'(zflag_l), 0);
      chk(zflag_r == 1'b0, "R1", "zflag_r in reset", int'(zflag_r), 0);
      chk(force_zero == 1'b0, "R1", "force_zero in reset", int'(force_zero), 0);
      chk(cnt_clr == 1'b0, "R1", "cnt_clr in reset", int'(cnt_clr), 0);
      rst_n = 1'b1;
      prev = '0;
      mon_on = 1'b1;
      repeat (3) @(negedge clk);

      // A: write 0 (R2, R3), then an early request (R9)
      wr(1'b0, e);
      push_flags(e, 1'b1, "R2");
      push(nth(e, 3), 0, 1'b1, "R3");
      fire_sync(1'b1, 1'b1, 1'b1, "R9", es);
      settle();

      // B: request while held (R6), then a restart during blanking (R8)
      fire_sync(1'b1, 1'b1, 1'b0, "R6", es);
      repeat (10) @(negedge clk);
      fire_sync(1'b1, 1'b0, 1'b1, "R8", es2);
      chk(force_zero == 1'b1, "R8", "force_zero held across restart", int'(force_zero), 1);
      settle();

      // C: release cancelled by a return to 0 (R11), then a real release (R4, R5)
      wr(1'b1, e);
      @(negedge clk);
      wr(1'b0, e2);
      repeat (40) @(negedge clk);
      chk(int_rst == 1'b1, "R11", "int_rst after cancelled release", int'(int_rst), 1);
      chk(zflag_l && zflag_r, "R11", "flags after cancelled release", int'(zflag_l & zflag_r), 1);
      wr(1'b1, e3);
      r = nth(e3, 2);
      push(r, 0, 1'b0, "R4");
      push_flags(nth(r, 2), 1'b0, "R5");
      settle();

      // D: request outside the window (R7)
      fire_sync(1'b0, 1'b0, 1'b0, "R7", es);
      chk(cnt_clr == 1'b0, "R7", "cnt_clr after ignored request", int'(cnt_clr), 0);
      chk(force_zero == 1'b0, "R7", "force_zero after ignored request", int'(force_zero), 0);
      repeat (30) @(negedge clk);
      chk(force_zero == 1'b0, "R7", "force_zero later", int'(force_zero), 0);

      // E: entry cancelled before its third strobe (R10)
      repeat (3) @(negedge clk);
      wr(1'b0, e);
      push_flags(e, 1'b1, "R2");
      @(negedge clk);
      wr(1'b1, e2);
      push_flags(nth(e2, 2), 1'b0, "R10");
      settle();
      repeat (40) @(negedge clk);
      chk(int_rst == 1'b0, "R10", "int_rst after cancelled entry", int'(int_rst), 0);

      // F: full cycle at another strobe phase (R2..R5)
      repeat (5) @(negedge clk);
      wr(1'b0, e);
      push_flags(e, 1'b1, "R2");
      push(nth(e, 3), 0, 1'b1, "R3");
      settle();
      repeat (3) @(negedge clk);
      wr(1'b1, e);
      r = nth(e, 2);
      push(r, 0, 1'b0, "R4");
      push_flags(nth(r, 2), 1'b0, "R5");
      settle();

      done = 1'b1;
      finish_run();
   end

endmodule